// File: doc/BRIEF.md
# Receive-Threshold RTS/CTS Flow Control

This block automates the modem handshake lines of one UART channel. It watches how full the receive FIFO is and, once automatic request-to-send is switched on, raises the active-low request-to-send line when the FIFO is nearly full. It lowers the line again after software has drained the FIFO far enough. The halt level and the resume level are separate, so the line does not chatter while the fill level hovers near a single boundary.

On the transmit side, the block brings the active-low clear-to-send input into the clock domain through a two-stage synchronizer. When automatic clear-to-send is on, it turns that input into a permit signal for the serializer. The serializer samples the permit only when it is about to begin a character. A character already leaving the line therefore always completes, and no further character begins while the remote end holds clear-to-send high.

When automation is off, request-to-send follows a manual control bit, and the permit stays open. Software programs the block through a small write port that has three register selects.

Top module: `hw_flow_ctl`

## Requirements
- R1: After reset, `rts_n` is 1, `tx_permit` is 1 and `cts_active` is 0.
- R2: When automatic RTS is off (enable register bit 6 = 0), a write to select 2 (modem control) drives `rts_n` to the inverse of data bit 1 from the next cycle on.
- R3: When automatic RTS is on, `rts_n` is 1 in the cycle after `rx_level` is at or above the halt level. The halt level is the threshold register bits [3:0] times 4.
- R4: When automatic RTS is on, `rts_n` stays 1 while `rx_level` lies strictly between the resume and halt levels. `rts_n` returns to 0 in the cycle after `rx_level` is at or below the resume level, which is bits [7:4] times 4. The resume level must be below the halt level.
- R5: When automatic RTS is on (select 1, bit 6 = 1), the manual modem control bit has no effect on `rts_n`. Turning automation off hands `rts_n` back to the manual bit.
- R6: `cts_active` equals the inverse of `cts_n` as it was two clock edges earlier. A change on `cts_n` is not visible after only one edge.
- R7: When automatic CTS is off (select 1, bit 7 = 0), `tx_permit` is 1 whatever the level of `cts_n`.
- R8: When automatic CTS is on, `tx_permit` is 0 while the synchronized `cts_n` is high and 1 while it is low.
- R9: A write with select 3 changes no register. Outputs that depend on the threshold, enable and modem control registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 threshold, 1 enable, 2 modem control, 3 unused |
| wr_data | input | 8 | Write data |
| rx_level | input | CNT_W (7) | Current receive FIFO fill count |
| cts_n | input | 1 | Clear-to-send from the remote end, active low, asynchronous |
| rts_n | output | 1 | Request-to-send to the remote end, active low |
| tx_permit | output | 1 | Serializer may start a new character |
| cts_active | output | 1 | Synchronized clear-to-send state, active high, for status reading |

## Verification
The bench builds the block with its defaults: a 64-entry FIFO, a threshold step of 4 and two synchronizer stages. With these values, a 4-bit threshold reaches 60, and the full fill range 0 to 64 can be driven. The bench places the halt level at 32 and the resume level at 16. It then walks `rx_level` through 31, 32, the band between the levels, 16 and 64, which reaches both edges of the hysteresis. The two-stage synchronizer makes the one-edge and two-edge sampling points of `cts_n` distinct, so the bench can observe each of them.

// File: rtl/hw_flow_ctl.sv
module hw_flow_ctl #(
  parameter int FIFO_DEPTH  = 64,
  parameter int THR_W       = 4,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             cts_active
);

  localparam logic [1:0] SEL_THR = 2'd0;
  localparam logic [1:0] SEL_ENA = 2'd1;
  localparam logic [1:0] SEL_MDM = 2'd2;

  logic [THR_W-1:0] thr_halt, thr_resume;
  logic             auto_rts, auto_cts, man_rts;
  logic             halted;
  logic [SYNC_STAGES-1:0] cts_sync;

  wire [CNT_W-1:0] halt_lvl   = CNT_W'(thr_halt)   * CNT_W'(STEP);
  wire [CNT_W-1:0] resume_lvl = CNT_W'(thr_resume) * CNT_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_halt   <= '0;
      thr_resume <= '0;
      auto_rts   <= 1'b0;
      auto_cts   <= 1'b0;
      man_rts    <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_THR: begin
          thr_halt   <= wr_data[THR_W-1:0];
          thr_resume <= wr_data[2*THR_W-1:THR_W];
        end
        SEL_ENA: begin
          auto_cts <= wr_data[7];
          auto_rts <= wr_data[6];
        end
        SEL_MDM: man_rts <= wr_data[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   halted <= 1'b0;
    else if (rx_level >= halt_lvl)  halted <= 1'b1;
    else if (rx_level <= resume_lvl) halted <= 1'b0;
  end

  assign rts_n = auto_rts ? halted : ~man_rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync <= '1;
    else        cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n};
  end

  assign cts_active = ~cts_sync[SYNC_STAGES-1];
  assign tx_permit  = ~auto_cts | cts_active;

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (rts_n && tx_permit && !cts_active) || !rst_n);

  p_manual_rts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MDM && !auto_rts) |=> rts_n == !$past(wr_data[1]));

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && auto_rts && rx_level >= halt_lvl) |=> rts_n);

  p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && auto_rts && halt_lvl > resume_lvl && rx_level <= resume_lvl) |=> !rts_n);

  p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && auto_rts && rts_n && rx_level > resume_lvl) |=> rts_n);

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> cts_active == !$past(cts_n, 2));

  p_cts_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && auto_cts && $past(cts_n, 2)) |-> !tx_permit);

endmodule

// File: tb/test_hw_flow_ctl.sv
module test_hw_flow_ctl;
  localparam int CNT_W = 7;

  logic clk = 0, rst_n = 0, wr_en = 0, cts_n = 1;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [CNT_W-1:0] rx_level = 0;
  logic rts_n, tx_permit, cts_active;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hw_flow_ctl i_hw_flow_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rx_level(rx_level), .cts_n(cts_n), .rts_n(rts_n), .tx_permit(tx_permit),
    .cts_active(cts_active));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_level(input int lvl);
    rx_level = CNT_W'(lvl);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rts_n", rts_n, 1'b1);
    check("R1 tx_permit", tx_permit, 1'b1);
    check("R1 cts_active", cts_active, 1'b0);
  endtask

  task automatic t_manual;
    wr(2'd2, 8'h02); check("R2 manual assert", rts_n, 1'b0);
    wr(2'd2, 8'h00); check("R2 manual deassert", rts_n, 1'b1);
  endtask

  task automatic t_auto;
    wr(2'd0, 8'h48);
    wr(2'd1, 8'h40);
    set_level(10); check("R3 below halt", rts_n, 1'b0);
    set_level(31); check("R3 one below halt", rts_n, 1'b0);
    set_level(32); check("R3 at halt", rts_n, 1'b1);
    set_level(20); check("R4 band hold", rts_n, 1'b1);
    set_level(17); check("R4 just above resume", rts_n, 1'b1);
    set_level(16); check("R4 at resume", rts_n, 1'b0);
    set_level(64); check("R3 full fifo", rts_n, 1'b1);
    wr(2'd2, 8'h00); check("R5 manual ignored", rts_n, 1'b1);
    set_level(0);  check("R5 manual ignored low", rts_n, 1'b0);
    wr(2'd2, 8'h00); check("R5 manual ignored deassert", rts_n, 1'b0);
    wr(2'd1, 8'h00); check("R5 handback", rts_n, 1'b1);
    wr(2'd2, 8'h02); check("R5 handback assert", rts_n, 1'b0);
  endtask

  task automatic t_ignored;
    wr(2'd3, 8'hFD);
    check("R9 rts_n kept", rts_n, 1'b0);
    check("R9 permit kept", tx_permit, 1'b1);
  endtask

  task automatic t_cts;
    cts_n = 1;
    repeat (3) @(negedge clk);
    check("R7 permit with cts high", tx_permit, 1'b1);
    wr(2'd1, 8'h80);
    check("R8 blocked", tx_permit, 1'b0);
    cts_n = 0;
    @(negedge clk);
    check("R6 one edge", cts_active, 1'b0);
    check("R8 still blocked", tx_permit, 1'b0);
    @(negedge clk);
    check("R6 two edges", cts_active, 1'b1);
    check("R8 permitted", tx_permit, 1'b1);
    cts_n = 1;
    repeat (2) @(negedge clk);
    check("R8 blocked again", tx_permit, 1'b0);
    wr(2'd1, 8'h00);
    check("R7 auto off", tx_permit, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_manual();
    t_auto();
    t_ignored();
    t_cts();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule